// File: doc/BRIEF.md
# Board Control Register Bank

This block is the control and status register bank of an evaluation board. A host writes and reads it over a plain 32-bit register bus made of an address, a write enable, write data and combinational read data. Only the low 20 address bits select a register, so the bank can sit at any base address.

The bank owns the state behind several board features:
- an 8-LED bar;
- a general-purpose output byte and a break/reset byte;
- an eight-character ASCII display buffer, with a one-cycle update strobe for a downstream display driver;
- a set of bit-banged I2C control registers, whose clock and data bits go to a serial EEPROM slave.

A few read-only identification registers return fixed values. A live serial-data input bit from the EEPROM slave can be read back. Writing one exact magic value to the soft-reset register produces a single-cycle system reset request.

The display buffer has two write paths:
- One register takes a 32-bit value and fills all eight characters with its uppercase hexadecimal rendering.
- Eight further registers each place one character.

Top module: `board_ctrl_regs`

## Requirements
- R1: Registers are selected by the exact value of address bits [19:0], and the upper address bits are ignored. A write to an offset that selects no register changes no output, and a read of such an offset returns 0.
- R2: The switch register (0x200) and the jumper register (0x210) always read 0. The status register (0x208) reads 0x12 when parameter BIG_ENDIAN is 1 (the default) and 0x10 when it is 0. Writes to these three registers have no effect.
- R3: A write to 0x408 stores data bits [7:0] in the LED register, which drives led_o and reads back zero-extended.
- R4: A write to 0x410 fills the whole display with the write data as eight uppercase hexadecimal ASCII digits. Digits 0-9 map to 0x30-0x39 and A-F to 0x41-0x46. Character 0 (disp_o[7:0]) holds the most significant nibble, and character 7 (disp_o[63:56]) holds the least significant.
- R5: A write to offset 0x418 + 8*k, for k from 0 to 7, stores data bits [7:0] into character k (disp_o[8k+7:8k]) and leaves the other characters unchanged. Offsets in that range that are not a multiple of 8 away from 0x418 are undecoded.
- R6: A write of exactly 0x00000042 to 0x500 raises soft_rst_o for exactly the one cycle after the write edge. Any other value, or any other offset, leaves soft_rst_o low.
- R7: The break register (0x508) and the GP output register (0xA00) keep data bits [7:0]. The I2C output-enable register (0xB08) keeps bits [1:0], and the I2C select register (0xB18) keeps bit [0]. Each reads back zero-extended and drives its output port.
- R8: A read of the GP input register (0xA08) returns the full I2C output register when the select bit is 1, and 0 when it is 0.
- R9: A read of the I2C input register (0xB00) returns 0x2 with bit 0 replaced by the live sda_i input.
- R10: A write to 0xB10 stores all 32 data bits as the I2C output register, which reads back in full. Bit 1 drives scl_o and bit 0 drives sda_o.
- R11: After reset the values are:
  - LED 0x00
  - break 0x0A
  - GP output 0x00
  - output-enable 0
  - I2C output 0x3
  - select 1
  - every display character 0x20
  - soft_rst_o and disp_upd_o low
- R12: disp_upd_o is high for exactly the one cycle after each write edge to 0x410 or to a character offset, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 32 | Register bus address |
| we_i | input | 1 | Write enable, one write per cycle it is high |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| sda_i | input | 1 | Live serial data bit from the EEPROM slave |
| led_o | output | 8 | LED bar |
| brk_o | output | 8 | Break/reset byte |
| gpo_o | output | 8 | General-purpose output byte |
| i2c_oe_o | output | 2 | I2C output-enable bits |
| i2c_sel_o | output | 1 | I2C select bit |
| scl_o | output | 1 | I2C clock line to the EEPROM |
| sda_o | output | 1 | I2C data line to the EEPROM |
| disp_o | output | 64 | Display buffer, character k in bits [8k+7:8k] |
| disp_upd_o | output | 1 | One-cycle display update strobe |
| soft_rst_o | output | 1 | One-cycle soft reset request |

## Verification
Most internal state is visible at the ports on the next cycle. A wrong register value shows on its output port one cycle after the write edge, and on rdata_o as soon as the address selects it. A decode fault that aliases two offsets shows as a second register changing, or as the wrong display character moving, after a single write. A soft-reset or display strobe that is stuck or stretched shows in the cycle after the write, and is caught by checking the strobe both in that cycle and in the one after it.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;
  localparam logic [19:0] OFF_SWITCH  = 20'h00200;
  localparam logic [19:0] OFF_STATUS  = 20'h00208;
  localparam logic [19:0] OFF_JUMPER  = 20'h00210;
  localparam logic [19:0] OFF_LED     = 20'h00408;
  localparam logic [19:0] OFF_HEXWORD = 20'h00410;
  localparam logic [19:0] OFF_CHAR0   = 20'h00418;
  localparam logic [19:0] OFF_SOFTRST = 20'h00500;
  localparam logic [19:0] OFF_BREAK   = 20'h00508;
  localparam logic [19:0] OFF_GPO     = 20'h00a00;
  localparam logic [19:0] OFF_GPI     = 20'h00a08;
  localparam logic [19:0] OFF_I2CIN   = 20'h00b00;
  localparam logic [19:0] OFF_I2COE   = 20'h00b08;
  localparam logic [19:0] OFF_I2COUT  = 20'h00b10;
  localparam logic [19:0] OFF_I2CSEL  = 20'h00b18;

  localparam logic [31:0] SOFTRST_MAGIC = 32'h0000_0042;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_SWITCH, SEL_STATUS, SEL_JUMPER, SEL_LED, SEL_HEXWORD,
    SEL_CHAR, SEL_SOFTRST, SEL_BREAK, SEL_GPO, SEL_GPI, SEL_I2CIN,
    SEL_I2COE, SEL_I2COUT, SEL_I2CSEL
  } reg_sel_e;

  function automatic logic [7:0] nib2ascii(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction
endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
  import board_ctrl_pkg::*;
#(
  parameter int OFF_W = 20,
  parameter int NCHAR = 8,
  localparam int IDX_W = (NCHAR > 1) ? $clog2(NCHAR) : 1
) (
  input  logic [OFF_W-1:0] off_i,
  output reg_sel_e         sel_o,
  output logic [IDX_W-1:0] char_idx_o
);
  localparam logic [OFF_W-1:0] CHAR_END = OFF_W'(OFF_CHAR0) + OFF_W'(8 * NCHAR);

  logic [OFF_W-1:0] char_rel;
  logic             in_char;

  assign char_rel   = off_i - OFF_W'(OFF_CHAR0);
  assign in_char    = (off_i >= OFF_W'(OFF_CHAR0)) && (off_i < CHAR_END) && (char_rel[2:0] == 3'b000);
  assign char_idx_o = char_rel[3 +: IDX_W];

  always_comb begin
    sel_o = SEL_NONE;
    if (in_char) sel_o = SEL_CHAR;
    else begin
      case (off_i)
        OFF_W'(OFF_SWITCH):  sel_o = SEL_SWITCH;
        OFF_W'(OFF_STATUS):  sel_o = SEL_STATUS;
        OFF_W'(OFF_JUMPER):  sel_o = SEL_JUMPER;
        OFF_W'(OFF_LED):     sel_o = SEL_LED;
        OFF_W'(OFF_HEXWORD): sel_o = SEL_HEXWORD;
        OFF_W'(OFF_SOFTRST): sel_o = SEL_SOFTRST;
        OFF_W'(OFF_BREAK):   sel_o = SEL_BREAK;
        OFF_W'(OFF_GPO):     sel_o = SEL_GPO;
        OFF_W'(OFF_GPI):     sel_o = SEL_GPI;
        OFF_W'(OFF_I2CIN):   sel_o = SEL_I2CIN;
        OFF_W'(OFF_I2COE):   sel_o = SEL_I2COE;
        OFF_W'(OFF_I2COUT):  sel_o = SEL_I2COUT;
        OFF_W'(OFF_I2CSEL):  sel_o = SEL_I2CSEL;
        default:             sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/bcr_display.sv
module bcr_display
  import board_ctrl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NCHAR  = 8,
  localparam int IDX_W = (NCHAR > 1) ? $clog2(NCHAR) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               word_we_i,
  input  logic               char_we_i,
  input  logic [IDX_W-1:0]   char_idx_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [8*NCHAR-1:0] text_o,
  output logic               upd_o
);
  logic [7:0] chars_q [NCHAR];

  for (genvar i = 0; i < NCHAR; i++) begin : g_char
    // character 0 takes the most significant nibble
    localparam int NIB = NCHAR - 1 - i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chars_q[i] <= 8'h20;
      else if (word_we_i) chars_q[i] <= nib2ascii(wdata_i[4*NIB +: 4]);
      else if (char_we_i && (char_idx_i == IDX_W'(i))) chars_q[i] <= wdata_i[7:0];
    end
    assign text_o[8*i +: 8] = chars_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upd_o <= 1'b0;
    else         upd_o <= word_we_i | char_we_i;
  end
endmodule

// File: rtl/bcr_strobe.sv
module bcr_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= 1'b0;
    else         pulse_o <= fire_i;
  end
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
  import board_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int OFF_W      = 20,
  parameter int NCHAR      = 8,
  parameter int BYTE_W     = 8,
  parameter int OE_W       = 2,
  parameter bit BIG_ENDIAN = 1'b1,
  localparam int IDX_W     = (NCHAR > 1) ? $clog2(NCHAR) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic               sda_i,
  output logic [BYTE_W-1:0]  led_o,
  output logic [BYTE_W-1:0]  brk_o,
  output logic [BYTE_W-1:0]  gpo_o,
  output logic [OE_W-1:0]    i2c_oe_o,
  output logic               i2c_sel_o,
  output logic               scl_o,
  output logic               sda_o,
  output logic [8*NCHAR-1:0] disp_o,
  output logic               disp_upd_o,
  output logic               soft_rst_o
);
  localparam logic [DATA_W-1:0] STATUS_VAL = BIG_ENDIAN ? DATA_W'(32'h12) : DATA_W'(32'h10);
  localparam logic [DATA_W-1:0] I2CIN_RST  = DATA_W'(32'h3);
  localparam logic [BYTE_W-1:0] BRK_RST    = BYTE_W'(8'h0a);

  reg_sel_e          sel;
  logic [IDX_W-1:0]  char_idx;
  logic [DATA_W-1:0] i2c_out_q;

  bcr_decode #(.OFF_W(OFF_W), .NCHAR(NCHAR)) u_decode (
    .off_i      (addr_i[OFF_W-1:0]),
    .sel_o      (sel),
    .char_idx_o (char_idx)
  );

  bcr_display #(.DATA_W(DATA_W), .NCHAR(NCHAR)) u_display (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_we_i  (we_i && (sel == SEL_HEXWORD)),
    .char_we_i  (we_i && (sel == SEL_CHAR)),
    .char_idx_i (char_idx),
    .wdata_i    (wdata_i),
    .text_o     (disp_o),
    .upd_o      (disp_upd_o)
  );

  bcr_strobe u_softrst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (we_i && (sel == SEL_SOFTRST) && (wdata_i == DATA_W'(SOFTRST_MAGIC))),
    .pulse_o (soft_rst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      led_o     <= '0;
      brk_o     <= BRK_RST;
      gpo_o     <= '0;
      i2c_oe_o  <= '0;
      i2c_sel_o <= 1'b1;
      i2c_out_q <= DATA_W'(32'h3);
    end else if (we_i) begin
      case (sel)
        SEL_LED:    led_o     <= wdata_i[BYTE_W-1:0];
        SEL_BREAK:  brk_o     <= wdata_i[BYTE_W-1:0];
        SEL_GPO:    gpo_o     <= wdata_i[BYTE_W-1:0];
        SEL_I2COE:  i2c_oe_o  <= wdata_i[OE_W-1:0];
        SEL_I2CSEL: i2c_sel_o <= wdata_i[0];
        SEL_I2COUT: i2c_out_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign scl_o = i2c_out_q[1];
  assign sda_o = i2c_out_q[0];

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_STATUS: rdata_o = STATUS_VAL;
      SEL_LED:    rdata_o = DATA_W'(led_o);
      SEL_BREAK:  rdata_o = DATA_W'(brk_o);
      SEL_GPO:    rdata_o = DATA_W'(gpo_o);
      SEL_GPI:    rdata_o = i2c_sel_o ? i2c_out_q : '0;
      SEL_I2CIN:  rdata_o = {I2CIN_RST[DATA_W-1:1], sda_i};
      SEL_I2COE:  rdata_o = DATA_W'(i2c_oe_o);
      SEL_I2COUT: rdata_o = i2c_out_q;
      SEL_I2CSEL: rdata_o = DATA_W'(i2c_sel_o);
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/board_ctrl_regs_chk.sv
module board_ctrl_regs_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              sda_i,
  input logic [7:0]        led_o,
  input logic              scl_o,
  input logic              disp_upd_o,
  input logic              soft_rst_o
);
  assert_softrst_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);

  assert_softrst_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> $past(we_i && (addr_i[19:0] == 20'h00500) && (wdata_i == 32'h42)));

  assert_upd_cause_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_upd_o |-> $past(we_i && (addr_i[19:0] >= 20'h00410) && (addr_i[19:0] <= 20'h00450)
                         && (addr_i[2:0] == 3'b000)));

  assert_led_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (addr_i[19:0] == 20'h00408)) |=> $stable(led_o));

  assert_scl_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (addr_i[19:0] == 20'h00b10)) |=> $stable(scl_o));

  assert_i2cin_live_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[19:0] == 20'h00b00) |-> (rdata_o == {30'b0, 1'b1, sda_i}));
endmodule

bind board_ctrl_regs board_ctrl_regs_chk u_chk (.*);

// File: tb/tb_board_ctrl_regs.sv
module tb_board_ctrl_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        sda_i = 1'b0;
  logic [7:0]  led_o, brk_o, gpo_o;
  logic [1:0]  i2c_oe_o;
  logic        i2c_sel_o, scl_o, sda_o;
  logic [63:0] disp_o;
  logic        disp_upd_o, soft_rst_o;

  int checks = 0;
  int fails = 0;
  logic seen_srst, seen_upd;
  string hexd = "0123456789ABCDEF";

  always #5 clk_i = ~clk_i;

  board_ctrl_regs dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; addr_i = 32'h0; wdata_i = '0;
    seen_srst = soft_rst_o;
    seen_upd  = disp_upd_o;
  endtask

  task automatic rd_chk(input string req, input logic [31:0] a, input logic [31:0] exp);
    @(negedge clk_i);
    addr_i = a;
    #1;
    chk(req, {32'h0, rdata_o}, {32'h0, exp});
    addr_i = 32'h0;
  endtask

  function automatic logic [63:0] hex_text(input logic [31:0] v);
    logic [63:0] t;
    for (int k = 0; k < 8; k++) t[8*k +: 8] = hexd[7-k];
    for (int k = 0; k < 8; k++) t[8*k +: 8] = hexd[(v >> (4*(7-k))) & 32'hf];
    return t;
  endfunction

  task automatic t_reset;
    chk("R11 led", led_o, 8'h00);
    chk("R11 brk", brk_o, 8'h0a);
    chk("R11 gpo", gpo_o, 8'h00);
    chk("R11 oe", i2c_oe_o, 2'b00);
    chk("R11 sel", i2c_sel_o, 1'b1);
    chk("R11 scl/sda", {scl_o, sda_o}, 2'b11);
    chk("R11 display", disp_o, {8{8'h20}});
    chk("R11 strobes", {disp_upd_o, soft_rst_o}, 2'b00);
    rd_chk("R11 i2cout read", 32'h00b10, 32'h3);
  endtask

  task automatic t_readonly;
    wr(32'h200, 32'hffff_ffff);
    wr(32'h210, 32'hffff_ffff);
    wr(32'h208, 32'hffff_ffff);
    rd_chk("R2 switch", 32'h200, 32'h0);
    rd_chk("R2 jumper", 32'h210, 32'h0);
    rd_chk("R2 status", 32'h208, 32'h12);
  endtask

  task automatic t_led;
    wr(32'h1f00_0408, 32'hdead_beA5);
    chk("R3 led_o", led_o, 8'ha5);
    rd_chk("R3 led read", 32'h408, 32'ha5);
    rd_chk("R1 aliased read", 32'h7ff0_0408, 32'ha5);
  endtask

  task automatic t_hexword;
    wr(32'h410, 32'h01AB_9CF7);
    chk("R12 upd after hexword", seen_upd, 1'b1);
    chk("R4 hex text", disp_o, hex_text(32'h01AB_9CF7));
    @(negedge clk_i);
    chk("R12 upd one cycle", disp_upd_o, 1'b0);
    wr(32'h410, 32'hFEDC_3456);
    chk("R4 hex text 2", disp_o, hex_text(32'hFEDC_3456));
  endtask

  task automatic t_chars;
    logic [63:0] exp;
    exp = disp_o;
    for (int k = 0; k < 8; k++) begin
      wr(32'h418 + 8*k, 32'hffff_ff00 | (8'h61 + k));
      exp[8*k +: 8] = 8'h61 + k;
      chk($sformatf("R5 char %0d", k), disp_o, exp);
      chk("R12 upd after char", seen_upd, 1'b1);
    end
    wr(32'h41c, 32'h5a);
    chk("R5 misaligned ignored", disp_o, exp);
    chk("R12 no upd misaligned", seen_upd, 1'b0);
    wr(32'h458, 32'h5a);
    chk("R5 past last char ignored", disp_o, exp);
  endtask

  task automatic t_softrst;
    wr(32'h500, 32'h42);
    chk("R6 pulse", seen_srst, 1'b1);
    @(negedge clk_i);
    chk("R6 pulse one cycle", soft_rst_o, 1'b0);
    wr(32'h500, 32'h43);
    chk("R6 wrong value", seen_srst, 1'b0);
    wr(32'h500, 32'h0100_0042);
    chk("R6 upper bits set", seen_srst, 1'b0);
    wr(32'h508, 32'h42);
    chk("R6 wrong offset", seen_srst, 1'b0);
  endtask

  task automatic t_misc;
    wr(32'h508, 32'h1234_5677);
    wr(32'ha00, 32'hffff_ff3c);
    wr(32'hb08, 32'hffff_fffe);
    wr(32'hb18, 32'hffff_fffe);
    chk("R7 brk_o", brk_o, 8'h77);
    chk("R7 gpo_o", gpo_o, 8'h3c);
    chk("R7 oe", i2c_oe_o, 2'b10);
    chk("R7 sel", i2c_sel_o, 1'b0);
    rd_chk("R7 brk read", 32'h508, 32'h77);
    rd_chk("R7 gpo read", 32'ha00, 32'h3c);
    rd_chk("R7 oe read", 32'hb08, 32'h2);
    rd_chk("R7 sel read", 32'hb18, 32'h0);
  endtask

  task automatic t_i2c;
    wr(32'hb10, 32'hcafe_f00d);
    chk("R10 scl/sda", {scl_o, sda_o}, 2'b01);
    rd_chk("R10 read", 32'hb10, 32'hcafe_f00d);
    rd_chk("R8 gpi sel=0", 32'ha08, 32'h0);
    wr(32'hb18, 32'h1);
    rd_chk("R8 gpi sel=1", 32'ha08, 32'hcafe_f00d);
    wr(32'hb10, 32'h2);
    chk("R10 scl/sda 2", {scl_o, sda_o}, 2'b10);
    sda_i = 1'b0;
    rd_chk("R9 sda low", 32'hb00, 32'h2);
    sda_i = 1'b1;
    rd_chk("R9 sda high", 32'hb00, 32'h3);
  endtask

  task automatic t_undecoded;
    logic [63:0] d;
    d = disp_o;
    wr(32'h404, 32'hffff_ffff);
    chk("R1 no strobe", {seen_upd, seen_srst}, 2'b00);
    chk("R1 outputs unchanged", {led_o, brk_o, gpo_o, i2c_oe_o, i2c_sel_o, scl_o, sda_o},
        {8'ha5, 8'h77, 8'h3c, 2'b10, 1'b1, 1'b1, 1'b0});
    chk("R1 display unchanged", disp_o, d);
    rd_chk("R1 undecoded read", 32'h404, 32'h0);
    rd_chk("R1 undecoded read 2", 32'h00fff, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_readonly;
    t_led;
    t_hexword;
    t_chars;
    t_softrst;
    t_misc;
    t_i2c;
    t_undecoded;
    repeat (2) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule